// File: doc/BRIEF.md
# General-Purpose Parallel Port Engine

This block moves words between an on-chip agent and a wide parallel pin interface that links to an FPGA or CPLD. The agent queues commands into a small transmit FIFO. Each command is either a write or a read, and it carries an address and a data word. The engine then plays the commands out on the pins one word at a time. Each word takes two enabled cycles. In the first cycle the clock output is low, and the strobe, address and data are presented. In the second cycle the clock output is high, so the far side samples on its rising edge. For a read, the pin input bus is captured when the word ends, and the captured value is queued in a receive FIFO for the agent to collect.

A frame output marks groups of words. Its length comes from a frame-length input that is treated as static configuration. The frame rises with the first word of a frame and stays high across that many words, including any stalls inside the frame. One enabled cycle with the frame low then separates it from the next frame. An optional clock-enable input freezes the whole pin side.

The following are fixed by parameters:
- the data width, up to 32 bits;
- the address width, 4 to 20 bits;
- whether the address field, the clock output and the clock-enable input are used.

Top module: `gpp_engine`

## Requirements
- R1: While reset is high and after it falls, all pin outputs are 0, tx_ready is 1 and rx_valid is 0.
- R2: A write command is played out in FIFO order as two enabled cycles with pin_wr high, pin_addr and pin_dout set to the command's fields. Address and data change only in a cycle where pin_clk is low.
- R3: A read command drives pin_rd high for two enabled cycles. The value on pin_din at the clock edge ending the second cycle is appended to the receive FIFO. rx_data shows the oldest entry while rx_valid is 1, and the entry is removed by rx_ready.
- R4: pin_clk is 1 exactly in the second cycle of each word and 0 in every other cycle, including idle cycles.
- R5: With cfg_frame_len = N > 0, pin_frame rises with the first word of a frame and stays high until N words have completed. It is then low for exactly one enabled cycle, after which the next word opens a new frame. With N = 0 the frame never closes.
- R6: When the transmit FIFO is empty inside a frame, idle cycles follow with both strobes and pin_clk at 0. pin_frame stays 1, and the frame word count is held, so the frame still closes after N words in total.
- R7: In a cycle where pin_cke is 0, no pin output and no frame count changes at the following edge. Agent-side FIFO traffic continues.
- R8: A read is not started unless the receive FIFO will have room for its word. Later commands wait behind it in order.
- R9: tx_ready is 0 when the transmit FIFO holds DEPTH commands. A command offered while tx_ready is 0 is dropped and never appears on the pins.
- R10: pin_rd and pin_wr are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_valid | input | 1 | Agent offers a command |
| tx_ready | output | 1 | Transmit FIFO can take a command |
| tx_rd | input | 1 | Command is a read (1) or a write (0) |
| tx_addr | input | AW | Command address |
| tx_data | input | DW | Write data (ignored for reads) |
| rx_valid | output | 1 | Receive FIFO holds a word |
| rx_ready | input | 1 | Agent takes the oldest received word |
| rx_data | output | DW | Oldest received word |
| cfg_frame_len | input | FLW | Words per frame, 0 for unbounded |
| pin_cke | input | 1 | Clock enable from the far side |
| pin_din | input | DW | Pin data input bus |
| pin_clk | output | 1 | Clock output, high in the second half of a word |
| pin_rd | output | 1 | Read strobe |
| pin_wr | output | 1 | Write strobe |
| pin_frame | output | 1 | Frame marker |
| pin_addr | output | AW | Address field |
| pin_dout | output | DW | Pin data output bus |

## Verification
The bench targets four kinds of case:
- **Frame boundaries with the FIFO running dry inside a frame.** A design that reset or advanced the word count during idle cycles would close the frame early or late. A design that dropped the frame marker during the stall would open a spurious frame.
- **A full receive FIFO.** A design that issued the read anyway would lose a captured word or reorder it.
- **Clock-enable pauses placed at random, including in the middle of a word.** Any output or counter that moved during a pause would shift the pin sequence against the reference.
- **Commands offered while the transmit FIFO is full.** A design that accepted or overwrote them would show extra or corrupted words on the pins.

// File: rtl/gpp_pkg.sv
package gpp_pkg;

    typedef enum logic [1:0] {
        SLOT_IDLE  = 2'd0,
        SLOT_LEAD  = 2'd1,
        SLOT_TRAIL = 2'd2,
        SLOT_GAP   = 2'd3
    } slot_e;

    localparam int MAX_DATA_W = 32;
    localparam int MIN_ADDR_W = 4;
    localparam int MAX_ADDR_W = 20;

    function automatic int ptr_width(input int depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

    function automatic bit room_for(input int used, input int incoming, input int depth);
        return (used + incoming) < depth;
    endfunction

endpackage

// File: rtl/gpp_fifo.sv
module gpp_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4,
    localparam int PW   = gpp_pkg::ptr_width(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic          empty,
    output logic [CW-1:0] count
);
    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wptr, rptr;
    logic          do_push, do_pop;

    assign empty   = (count == '0);
    assign do_push = push && (int'(count) < DEPTH);
    assign do_pop  = pop && !empty;
    assign dout    = mem[rptr];

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (int'(p) == DEPTH - 1) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= bump(wptr);
            if (do_pop)  rptr <= bump(rptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= din;
    end
endmodule

// File: rtl/gpp_frame_ctr.sv
module gpp_frame_ctr #(
    parameter int FLW = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           done,
    input  logic [FLW-1:0] len,
    output logic           close
);
    logic [FLW-1:0] words;
    logic           bounded;

    assign bounded = (len != '0);
    assign close   = done && bounded && ((words + FLW'(1)) == len);

    always_ff @(posedge clk) begin
        if (rst) begin
            words <= '0;
        end else if (done && bounded) begin
            words <= close ? '0 : words + FLW'(1);
        end
    end
endmodule

// File: rtl/gpp_slot_ctrl.sv
module gpp_slot_ctrl
    import gpp_pkg::*;
#(
    parameter int DW         = 32,
    parameter int AW         = 12,
    parameter int DEPTH      = 4,
    parameter int FLW        = 8,
    parameter bit USE_ADDR   = 1'b1,
    parameter bit USE_CLKOUT = 1'b1,
    localparam int CW        = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           adv,
    input  logic           head_valid,
    input  logic           head_rd,
    input  logic [AW-1:0]  head_addr,
    input  logic [DW-1:0]  head_data,
    output logic           head_pop,
    input  logic [CW-1:0]  rx_count,
    output logic           rx_push,
    input  logic [FLW-1:0] frame_len,
    output logic           pin_clk,
    output logic           pin_rd,
    output logic           pin_wr,
    output logic           pin_frame,
    output logic [AW-1:0]  pin_addr,
    output logic [DW-1:0]  pin_dout
);
    slot_e slot;
    logic  in_frame;
    logic  boundary, word_done, closing, take, head_ok;

    assign boundary  = (slot != SLOT_LEAD);
    assign word_done = adv && (slot == SLOT_TRAIL);
    assign rx_push   = word_done && pin_rd;
    assign head_ok   = head_valid &&
                       (!head_rd || room_for(int'(rx_count), int'(rx_push), DEPTH));
    assign take      = adv && boundary && !closing && head_ok;
    assign head_pop  = take;

    gpp_frame_ctr #(.FLW(FLW)) u_frame_ctr (
        .clk   (clk),
        .rst   (rst),
        .done  (word_done),
        .len   (frame_len),
        .close (closing)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            slot      <= SLOT_IDLE;
            in_frame  <= 1'b0;
            pin_clk   <= 1'b0;
            pin_rd    <= 1'b0;
            pin_wr    <= 1'b0;
            pin_frame <= 1'b0;
            pin_addr  <= '0;
            pin_dout  <= '0;
        end else if (adv) begin
            if (slot == SLOT_LEAD) begin
                slot    <= SLOT_TRAIL;
                pin_clk <= USE_CLKOUT;
            end else begin
                pin_clk <= 1'b0;
                if (closing) begin
                    slot      <= SLOT_GAP;
                    in_frame  <= 1'b0;
                    pin_rd    <= 1'b0;
                    pin_wr    <= 1'b0;
                    pin_frame <= 1'b0;
                end else if (take) begin
                    slot      <= SLOT_LEAD;
                    in_frame  <= 1'b1;
                    pin_rd    <= head_rd;
                    pin_wr    <= !head_rd;
                    pin_frame <= 1'b1;
                    pin_addr  <= USE_ADDR ? head_addr : '0;
                    pin_dout  <= head_data;
                end else begin
                    slot      <= SLOT_IDLE;
                    pin_rd    <= 1'b0;
                    pin_wr    <= 1'b0;
                    pin_frame <= in_frame;
                end
            end
        end
    end
endmodule

// File: rtl/gpp_engine.sv
module gpp_engine
    import gpp_pkg::*;
#(
    parameter int DW         = 32,
    parameter int AW         = 12,
    parameter int DEPTH      = 4,
    parameter int FLW        = 8,
    parameter bit USE_ADDR   = 1'b1,
    parameter bit USE_CLKOUT = 1'b1,
    parameter bit USE_CKE    = 1'b1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           tx_valid,
    output logic           tx_ready,
    input  logic           tx_rd,
    input  logic [AW-1:0]  tx_addr,
    input  logic [DW-1:0]  tx_data,
    output logic           rx_valid,
    input  logic           rx_ready,
    output logic [DW-1:0]  rx_data,
    input  logic [FLW-1:0] cfg_frame_len,
    input  logic           pin_cke,
    input  logic [DW-1:0]  pin_din,
    output logic           pin_clk,
    output logic           pin_rd,
    output logic           pin_wr,
    output logic           pin_frame,
    output logic [AW-1:0]  pin_addr,
    output logic [DW-1:0]  pin_dout
);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic          rd;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } cmd_t;

    generate
        if (DW < 1 || DW > MAX_DATA_W) begin : g_bad_dw
            $error("gpp_engine: DW out of range");
        end
        if (AW < MIN_ADDR_W || AW > MAX_ADDR_W) begin : g_bad_aw
            $error("gpp_engine: AW out of range");
        end
    endgenerate

    logic adv;
    generate
        if (USE_CKE) begin : g_cke
            assign adv = pin_cke;
        end else begin : g_free
            assign adv = 1'b1;
        end
    endgenerate

    cmd_t          tx_in, tx_head;
    logic          tx_empty, tx_pop;
    logic [CW-1:0] tx_count;
    logic          rx_empty, rx_push;
    logic [CW-1:0] rx_count;

    assign tx_in    = '{rd: tx_rd, addr: tx_addr, data: tx_data};
    assign tx_ready = (int'(tx_count) < DEPTH);
    assign rx_valid = !rx_empty;

    gpp_fifo #(.W($bits(cmd_t)), .DEPTH(DEPTH)) u_tx_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (tx_valid),
        .din   (tx_in),
        .pop   (tx_pop),
        .dout  (tx_head),
        .empty (tx_empty),
        .count (tx_count)
    );

    gpp_fifo #(.W(DW), .DEPTH(DEPTH)) u_rx_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (rx_push),
        .din   (pin_din),
        .pop   (rx_ready),
        .dout  (rx_data),
        .empty (rx_empty),
        .count (rx_count)
    );

    gpp_slot_ctrl #(
        .DW(DW), .AW(AW), .DEPTH(DEPTH), .FLW(FLW),
        .USE_ADDR(USE_ADDR), .USE_CLKOUT(USE_CLKOUT)
    ) u_slot_ctrl (
        .clk        (clk),
        .rst        (rst),
        .adv        (adv),
        .head_valid (!tx_empty),
        .head_rd    (tx_head.rd),
        .head_addr  (tx_head.addr),
        .head_data  (tx_head.data),
        .head_pop   (tx_pop),
        .rx_count   (rx_count),
        .rx_push    (rx_push),
        .frame_len  (cfg_frame_len),
        .pin_clk    (pin_clk),
        .pin_rd     (pin_rd),
        .pin_wr     (pin_wr),
        .pin_frame  (pin_frame),
        .pin_addr   (pin_addr),
        .pin_dout   (pin_dout)
    );
endmodule

// File: rtl/gpp_engine_chk.sv
module gpp_engine_chk #(
    parameter int DW      = 32,
    parameter int AW      = 12,
    parameter bit USE_CKE = 1'b1
) (
    input logic          clk,
    input logic          rst,
    input logic          pin_cke,
    input logic          pin_clk,
    input logic          pin_rd,
    input logic          pin_wr,
    input logic          pin_frame,
    input logic [AW-1:0] pin_addr,
    input logic [DW-1:0] pin_dout
);
    // R10: strobes are exclusive
    a_r10_one_strobe: assert property (@(posedge clk) disable iff (rst)
        !(pin_rd && pin_wr));

    // R7: a paused cycle leaves every pin output unchanged
    a_r7_pause_holds: assert property (@(posedge clk) disable iff (rst)
        (USE_CKE && !pin_cke) |=>
            $stable({pin_clk, pin_rd, pin_wr, pin_frame, pin_addr, pin_dout}));

    // R2: data and address move only while the clock output is low
    a_r2_launch_low: assert property (@(posedge clk) disable iff (rst)
        !$stable({pin_addr, pin_dout}) |-> !pin_clk);

    // R4: the rising edge of the clock output sees settled address and data
    a_r4_rise_settled: assert property (@(posedge clk) disable iff (rst)
        $rose(pin_clk) |-> ($stable(pin_addr) && $stable(pin_dout)));

    // R4: the clock output is high only inside a word
    a_r4_clk_in_word: assert property (@(posedge clk) disable iff (rst)
        pin_clk |-> (pin_rd || pin_wr));

    // R5: every strobed word lies inside a frame
    a_r5_word_in_frame: assert property (@(posedge clk) disable iff (rst)
        (pin_rd || pin_wr) |-> pin_frame);
endmodule

bind gpp_engine gpp_engine_chk #(.DW(DW), .AW(AW), .USE_CKE(USE_CKE)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .pin_cke   (pin_cke),
    .pin_clk   (pin_clk),
    .pin_rd    (pin_rd),
    .pin_wr    (pin_wr),
    .pin_frame (pin_frame),
    .pin_addr  (pin_addr),
    .pin_dout  (pin_dout)
);

// File: tb/gpp_engine_bench.sv
module gpp_engine_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 32, AW = 12, DEPTH = 4, FLW = 8;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic rst = 1'b1, tx_valid = 1'b0, tx_rd = 1'b0, rx_ready = 1'b0, pin_cke = 1'b1;
    logic [AW-1:0] tx_addr = '0;
    logic [DW-1:0] tx_data = '0, pin_din = '0;
    logic [FLW-1:0] cfg_frame_len = '0;
    logic tx_ready, rx_valid, pin_clk, pin_rd, pin_wr, pin_frame;
    logic [DW-1:0] rx_data, pin_dout;
    logic [AW-1:0] pin_addr;

    gpp_engine u_gpp_engine (
        .clk(clk), .rst(rst), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_rd(tx_rd),
        .tx_addr(tx_addr), .tx_data(tx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .rx_data(rx_data), .cfg_frame_len(cfg_frame_len), .pin_cke(pin_cke),
        .pin_din(pin_din), .pin_clk(pin_clk), .pin_rd(pin_rd), .pin_wr(pin_wr),
        .pin_frame(pin_frame), .pin_addr(pin_addr), .pin_dout(pin_dout));

    int vectors = 0, miscompares = 0;
    string tag = "R1 reset";
    bit rand_cke = 0, rand_rx = 0, last_push = 0;

    // behavioural reference
    int m_slot, m_cnt;
    bit m_inf, m_rd;
    bit o_clk, o_rd, o_wr, o_frame;
    logic [AW-1:0] o_addr;
    logic [DW-1:0] o_dout;
    bit q_rd[$];
    logic [AW-1:0] q_addr[$];
    logic [DW-1:0] q_data[$];
    logic [DW-1:0] rq[$];

    task automatic model_reset();
        m_slot = 0; m_cnt = 0; m_inf = 0; m_rd = 0;
        o_clk = 0; o_rd = 0; o_wr = 0; o_frame = 0; o_addr = '0; o_dout = '0;
        q_rd.delete(); q_addr.delete(); q_data.delete(); rq.delete();
        last_push = 0;
    endtask

    task automatic model_step();
        bit push_ok, rx_pop, rx_add, tx_take, done, closing;
        int rxn;
        logic [DW-1:0] cap;
        push_ok = tx_valid && (q_rd.size() < DEPTH);
        rxn = rq.size();
        rx_pop = rx_ready && (rxn > 0);
        rx_add = 0; tx_take = 0; cap = '0;
        if (pin_cke) begin
            if (m_slot == 1) begin
                m_slot = 2; o_clk = 1;
            end else begin
                done = (m_slot == 2); closing = 0; o_clk = 0;
                if (done) begin
                    if (m_rd) begin rx_add = 1; cap = pin_din; end
                    if (cfg_frame_len != 0) begin
                        m_cnt++;
                        if (m_cnt == int'(cfg_frame_len)) begin closing = 1; m_cnt = 0; end
                    end
                end
                if (closing) begin
                    m_slot = 3; o_rd = 0; o_wr = 0; o_frame = 0; m_inf = 0;
                end else if (q_rd.size() > 0 && (!q_rd[0] || rxn + int'(rx_add) < DEPTH)) begin
                    tx_take = 1; m_slot = 1; m_rd = q_rd[0];
                    o_rd = m_rd; o_wr = !m_rd; o_frame = 1; m_inf = 1;
                    o_addr = q_addr[0]; o_dout = q_data[0];
                end else begin
                    m_slot = 0; o_rd = 0; o_wr = 0; o_frame = m_inf;
                end
            end
        end
        if (rx_pop) void'(rq.pop_front());
        if (rx_add) rq.push_back(cap);
        if (tx_take) begin void'(q_rd.pop_front()); void'(q_addr.pop_front()); void'(q_data.pop_front()); end
        if (push_ok) begin q_rd.push_back(tx_rd); q_addr.push_back(tx_addr); q_data.push_back(tx_data); end
        last_push = push_ok;
    endtask

    task automatic chk1(string what, string req, logic [63:0] act, logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s [%s] t=%0t: actual %h expected %h", req, what, tag, $time, act, exp);
        end
    endtask

    task automatic compare();
        chk1("tx_ready", "R9", 64'(tx_ready), 64'(q_rd.size() < DEPTH));
        chk1("rx_valid", "R3", 64'(rx_valid), 64'(rq.size() > 0));
        if (rq.size() > 0) chk1("rx_data", "R3", 64'(rx_data), 64'(rq[0]));
        chk1("pin_clk", "R4", 64'(pin_clk), 64'(o_clk));
        chk1("pin_rd", "R3", 64'(pin_rd), 64'(o_rd));
        chk1("pin_wr", "R2", 64'(pin_wr), 64'(o_wr));
        chk1("pin_frame", "R5", 64'(pin_frame), 64'(o_frame));
        chk1("pin_addr", "R2", 64'(pin_addr), 64'(o_addr));
        chk1("pin_dout", "R2", 64'(pin_dout), 64'(o_dout));
        chk1("strobes exclusive", "R10", 64'(pin_rd && pin_wr), 64'd0);
    endtask

    task automatic step();
        if (rand_cke) pin_cke = ($urandom % 4) != 0;
        if (rand_rx) rx_ready = $urandom % 2;
        pin_din = $urandom;
        if (rst) model_reset(); else model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic send(bit rd, logic [AW-1:0] a, logic [DW-1:0] d);
        tx_valid = 1; tx_rd = rd; tx_addr = a; tx_data = d;
        do step(); while (!last_push);
        tx_valid = 0;
    endtask

    task automatic phase(string t, int flen);
        tag = t;
        rand_cke = 0; rand_rx = 0; pin_cke = 1; rx_ready = 1; tx_valid = 0;
        rst = 1; cfg_frame_len = FLW'(flen);
        run(2);
        rst = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        miscompares++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        @(negedge clk);
        phase("R1 reset", 0);
        run(3);
        // R1: explicit post-reset state
        chk1("reset outputs", "R1", 64'({pin_clk, pin_rd, pin_wr, pin_frame, rx_valid}), 64'd0);
        chk1("reset ready", "R1", 64'(tx_ready), 64'd1);

        phase("R2 writes", 0);
        send(0, 12'h0a1, 32'h1111_0001);
        send(0, 12'h0a2, 32'h2222_0002);
        send(0, 12'h0a3, 32'h3333_0003);
        run(10);

        phase("R5 framing", 3);
        for (int i = 0; i < 7; i++) send(0, AW'(i), 32'hf000_0000 + i);
        run(20);

        phase("R3 reads", 2);
        for (int i = 0; i < 3; i++) send(1, AW'(16 + i), '0);
        run(12);

        phase("R8 rx full", 2);
        rx_ready = 0;
        for (int i = 0; i < 6; i++) send(1, AW'(32 + i), '0);
        send(0, 12'h0ee, 32'hdead_0008);
        run(20);
        rx_ready = 1;
        run(30);

        phase("R6 stall", 4);
        send(0, 12'h101, 32'h6000_0001);
        send(0, 12'h102, 32'h6000_0002);
        run(12);
        send(0, 12'h103, 32'h6000_0003);
        send(0, 12'h104, 32'h6000_0004);
        run(12);
        send(0, 12'h105, 32'h6000_0005);
        run(12);

        phase("R7 pause", 3);
        rand_cke = 1; rand_rx = 1;
        for (int i = 0; i < 12; i++) send(i % 3 == 0, AW'($urandom), $urandom);
        run(60);

        phase("R9 full", 0);
        pin_cke = 0;
        for (int i = 0; i < 8; i++) begin
            tx_valid = 1; tx_rd = 0; tx_addr = AW'(64 + i); tx_data = 32'h9000_0000 + i;
            step();
        end
        tx_valid = 0;
        pin_cke = 1;
        run(30);

        phase("R4 mix", 5);
        rand_cke = 1; rand_rx = 1;
        for (int i = 0; i < 400; i++) begin
            if ($urandom % 3 == 0) send($urandom % 2, AW'($urandom), $urandom);
            else step();
        end
        rand_cke = 0; pin_cke = 1; rx_ready = 1;
        run(60);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule